// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a logical address from a processor into a physical address using fixed-size pages. The logical address splits into a page number (upper bits) and an offset (lower `PG_BITS` bits). A small fully associative translation cache holds recent page-to-frame pairs. All of its entries are compared with the incoming page number at the same time. On a hit the physical address comes back one cycle after the request, with no memory traffic.

On a miss the block makes one read of main memory through a simple read port. The read address is the page-table base plus the page number, and the word that comes back is the frame number. The block writes the new pair into the cache, replacing entries in round-robin order once the cache is full, and then completes the translation. Only one translation is in flight at a time. A flush input empties the cache, for use when software moves the page table.

Top module: `pg_xlate`

## Requirements
- R1: The physical address is the frame number shifted left by `PG_BITS`, with the low `PG_BITS` offset bits copied unchanged from the logical address. The page number is logical address bits `[LA_W-1:PG_BITS]`.
- R2: After reset the cache holds no valid entry, so the first access to any page causes a table read.
- R3: A request accepted with a cache hit raises `done`, with the physical address, on the first clock edge after acceptance, and makes no memory read.
- R4: A request accepted with a cache miss raises `mem_rd` on the next edge. `mem_addr` equals `pt_base + page` modulo 2^(FR_W+PG_BITS). Both stay steady until the cycle in which `mem_rvld` is high. Exactly one read is issued, and `done` rises on the edge that samples `mem_rvld`, with the frame taken from `mem_rdata`.
- R5: After a miss, the new mapping is held in the cache, so a repeat access to the same page hits.
- R6: When all `TLB_N` entries are valid, a fill replaces the entry filled longest ago (round-robin order).
- R7: A one-cycle pulse on `flush` invalidates every entry, and the next access to any page causes a table read.
- R8: A request is accepted only while no translation is in progress. `req_vld` raised during a table read is ignored and produces no `done` and no extra memory read.
- R9: While reset is held, `done` and `mem_rd` are low.
- R10: `done` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Translation request strobe |
| req_laddr | input | LA_W | Logical address to translate |
| pt_base | input | FR_W+PG_BITS | Page-table base address, sampled when a request is accepted |
| flush | input | 1 | Invalidate all cache entries |
| mem_rd | output | 1 | Page-table read request, held until data returns |
| mem_addr | output | FR_W+PG_BITS | Page-table word address |
| mem_rvld | input | 1 | Read data valid |
| mem_rdata | input | FR_W | Frame number read from the page table |
| done | output | 1 | Translation complete, one-cycle pulse |
| paddr | output | FR_W+PG_BITS | Physical address, valid with `done` |

## Verification
The worked mappings with 4-byte pages (page 0 to frame 5, page 3 to frame 2) are run first, and a sweep of every offset of one page shows that the offset passes through. A sequence that fills the cache and then touches one page more separates round-robin eviction from other replacement policies. A revisit of the evicted page and of a surviving page shows which entry was lost. A flush followed by a change of table base separates stale cache contents from fresh table reads. A request strobe injected during a slow table read shows that a busy translator ignores new work. A long pseudo-random page stream is then checked against a behavioural queue model, with the latency, the address and the read count compared for every access.

// File: rtl/pg_xlate_pkg.sv
// Shared types for the paged address translator.
package pg_xlate_pkg;
    // Translator sequencing: waiting for a request, or waiting on a page-table read.
    typedef enum logic [0:0] {
        XS_IDLE = 1'b0,
        XS_WALK = 1'b1
    } xlate_state_t;
endpackage

// File: rtl/pg_xlate_tlb.sv
// Fully associative translation cache.
// Compares the lookup page against all entries at once and returns the
// matching frame. Fills go to the slot under a round-robin pointer. Since
// fills only happen on a miss and the pointer restarts on flush, entries
// fill in order and a full cache evicts its oldest fill.
// Assumes TLB_N >= 2, and that a page is never filled while it is present.
module pg_xlate_tlb #(
    parameter int TLB_N = 4,
    parameter int PN_W  = 6,
    parameter int FR_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PN_W-1:0] look_page,
    output logic            hit,
    output logic [FR_W-1:0] hit_frame,
    input  logic            fill_en,
    input  logic [PN_W-1:0] fill_page,
    input  logic [FR_W-1:0] fill_frame,
    input  logic            flush
);
    localparam int IDX_W = $clog2(TLB_N);

    logic [TLB_N-1:0] vld;
    logic [PN_W-1:0]  tag   [TLB_N];
    logic [FR_W-1:0]  frame [TLB_N];
    logic [TLB_N-1:0] match;
    logic [IDX_W-1:0] ptr;

    // One comparator per entry, all working in parallel.
    for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == look_page);
    end

    assign hit = |match;

    // Merge the frame of the single matching entry.
    always_comb begin
        hit_frame = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (match[i]) hit_frame = hit_frame | frame[i];
        end
    end

    // Valid bits and replacement pointer; flush wins over a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
            ptr <= '0;
        end else if (fill_en) begin
            vld[ptr] <= 1'b1;
            if (ptr == IDX_W'(TLB_N - 1)) ptr <= '0;
            else                          ptr <= ptr + 1'b1;
        end
    end

    // Entry payload written at the pointer slot.
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag[ptr]   <= fill_page;
            frame[ptr] <= fill_frame;
        end
    end

    // R6
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/pg_xlate_walk.sv
// Translation sequencer.
// In idle it accepts a request. A cache hit completes on the next edge. A
// miss starts a page-table read at base plus page and holds it until data
// returns, then fills the cache and completes. Requests during a read are
// ignored. Assumes PN_W <= PA_W.
module pg_xlate_walk
    import pg_xlate_pkg::*;
#(
    parameter int PN_W    = 6,
    parameter int FR_W    = 6,
    parameter int PG_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_vld,
    input  logic [PN_W-1:0]         req_page,
    input  logic [PG_BITS-1:0]      req_off,
    input  logic [FR_W+PG_BITS-1:0] pt_base,
    input  logic                    tlb_hit,
    input  logic [FR_W-1:0]         tlb_frame,
    output logic                    fill_en,
    output logic [PN_W-1:0]         fill_page,
    output logic [FR_W-1:0]         fill_frame,
    output logic                    mem_rd,
    output logic [FR_W+PG_BITS-1:0] mem_addr,
    input  logic                    mem_rvld,
    input  logic [FR_W-1:0]         mem_rdata,
    output logic                    done,
    output logic [FR_W+PG_BITS-1:0] paddr
);
    localparam int PA_W = FR_W + PG_BITS;

    xlate_state_t       st;
    logic [PN_W-1:0]    page_q;
    logic [PG_BITS-1:0] off_q;

    // Cache fill happens on the cycle the table word arrives.
    assign fill_en    = (st == XS_WALK) && mem_rvld;
    assign fill_page  = page_q;
    assign fill_frame = mem_rdata;

    // Request acceptance, table read sequencing and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= XS_IDLE;
            mem_rd   <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            paddr    <= '0;
            page_q   <= '0;
            off_q    <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                XS_IDLE: begin
                    if (req_vld) begin
                        page_q <= req_page;
                        off_q  <= req_off;
                        if (tlb_hit) begin
                            done  <= 1'b1;
                            paddr <= {tlb_frame, req_off};
                        end else begin
                            st       <= XS_WALK;
                            mem_rd   <= 1'b1;
                            mem_addr <= pt_base + PA_W'(req_page);
                        end
                    end
                end
                XS_WALK: begin
                    if (mem_rvld) begin
                        st     <= XS_IDLE;
                        mem_rd <= 1'b0;
                        done   <= 1'b1;
                        paddr  <= {mem_rdata, off_q};
                    end
                end
                default: st <= XS_IDLE;
            endcase
        end
    end

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rvld) |=> mem_rd);

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rvld) |=> $stable(mem_addr));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == XS_IDLE && req_vld && tlb_hit) |=> (done && !mem_rd));

    // R8
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rvld) |=> !done);
endmodule

// File: rtl/pg_xlate.sv
// Paged address translator top level.
// Splits the logical address into page and offset, looks the page up in
// the translation cache, and walks the in-memory page table on a miss.
// Assumes one page-table word per page holding a frame number.
module pg_xlate #(
    parameter int LA_W    = 8,
    parameter int PG_BITS = 2,
    parameter int FR_W    = 6,
    parameter int TLB_N   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_vld,
    input  logic [LA_W-1:0]         req_laddr,
    input  logic [FR_W+PG_BITS-1:0] pt_base,
    input  logic                    flush,
    output logic                    mem_rd,
    output logic [FR_W+PG_BITS-1:0] mem_addr,
    input  logic                    mem_rvld,
    input  logic [FR_W-1:0]         mem_rdata,
    output logic                    done,
    output logic [FR_W+PG_BITS-1:0] paddr
);
    localparam int PN_W = LA_W - PG_BITS;

    logic [PN_W-1:0]    look_page;
    logic [PG_BITS-1:0] look_off;
    logic               tlb_hit;
    logic [FR_W-1:0]    tlb_frame;
    logic               fill_en;
    logic [PN_W-1:0]    fill_page;
    logic [FR_W-1:0]    fill_frame;

    // Field split of the logical address.
    assign look_page = req_laddr[LA_W-1:PG_BITS];
    assign look_off  = req_laddr[PG_BITS-1:0];

    pg_xlate_tlb #(.TLB_N(TLB_N), .PN_W(PN_W), .FR_W(FR_W)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_page  (look_page),
        .hit        (tlb_hit),
        .hit_frame  (tlb_frame),
        .fill_en    (fill_en),
        .fill_page  (fill_page),
        .fill_frame (fill_frame),
        .flush      (flush)
    );

    pg_xlate_walk #(.PN_W(PN_W), .FR_W(FR_W), .PG_BITS(PG_BITS)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld    (req_vld),
        .req_page   (look_page),
        .req_off    (look_off),
        .pt_base    (pt_base),
        .tlb_hit    (tlb_hit),
        .tlb_frame  (tlb_frame),
        .fill_en    (fill_en),
        .fill_page  (fill_page),
        .fill_frame (fill_frame),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rvld   (mem_rvld),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .paddr      (paddr)
    );

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !mem_rd && tlb_hit) |=> (paddr[PG_BITS-1:0] == $past(look_off)));
endmodule

// File: tb/pg_xlate_tb.sv
module pg_xlate_tb;
    localparam int LA_W = 8, PG_BITS = 2, FR_W = 6, TLB_N = 4;
    localparam int PA_W = FR_W + PG_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0;
    logic [LA_W-1:0] req_laddr = '0;
    logic [PA_W-1:0] pt_base = '0;
    logic flush = 1'b0;
    logic mem_rd;
    logic [PA_W-1:0] mem_addr;
    logic mem_rvld = 1'b0;
    logic [FR_W-1:0] mem_rdata = '0;
    logic done;
    logic [PA_W-1:0] paddr;

    int total = 0, bad = 0;
    int ptmem [256];
    int mem_lat = 0;
    int lat_cnt = 0;
    int mem_reads = 0;
    int last_addr = 0;
    int q_pg [$];
    int q_fr [$];
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    pg_xlate #(.LA_W(LA_W), .PG_BITS(PG_BITS), .FR_W(FR_W), .TLB_N(TLB_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_laddr(req_laddr),
        .pt_base(pt_base), .flush(flush), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvld(mem_rvld), .mem_rdata(mem_rdata), .done(done), .paddr(paddr)
    );

    // Behavioural page-table memory, answering after mem_lat wait cycles.
    always @(negedge clk) begin
        if (mem_rvld) begin
            mem_rvld <= 1'b0;
        end else if (mem_rd) begin
            if (lat_cnt == mem_lat) begin
                lat_cnt   <= 0;
                mem_rvld  <= 1'b1;
                mem_rdata <= FR_W'(ptmem[int'(mem_addr)]);
                mem_reads <= mem_reads + 1;
                last_addr <= int'(mem_addr);
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One translation, checked against the queue model. inject: raise req_vld mid-walk.
    task automatic xlat(input int la, input bit inject, input string req);
        int pg = la >> PG_BITS;
        int off = la & ((1 << PG_BITS) - 1);
        int idx = -1;
        int fr, exp_cyc, cyc, reads0, n_done;
        for (int i = 0; i < q_pg.size(); i++) if (q_pg[i] == pg) idx = i;
        if (idx >= 0) begin
            fr = q_fr[idx];
            exp_cyc = 1;
        end else begin
            fr = ptmem[(int'(pt_base) + pg) & 255];
            exp_cyc = 2 + mem_lat;
            q_pg.push_back(pg);
            q_fr.push_back(fr);
            if (q_pg.size() > TLB_N) begin
                void'(q_pg.pop_front());
                void'(q_fr.pop_front());
            end
        end
        reads0 = mem_reads;
        @(negedge clk);
        req_vld = 1'b1;
        req_laddr = LA_W'(la);
        @(negedge clk);
        req_vld = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            if (inject && cyc == 1) begin
                req_vld = 1'b1;
                req_laddr = LA_W'(la ^ 8'h80);
            end else begin
                req_vld = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_vld = 1'b0;
        check(req, cyc, exp_cyc, "latency");
        check(req, int'(paddr), fr * (1 << PG_BITS) + off, "paddr");
        check(req, mem_reads - reads0, (idx >= 0) ? 0 : 1, "table reads");
        if (idx < 0) check(req, last_addr, (int'(pt_base) + pg) & 255, "table addr");
        n_done = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (done) n_done++;
        end
        check("R10/R8", n_done, 0, "extra done pulses");
        check("R8", mem_reads - reads0, (idx >= 0) ? 0 : 1, "reads after done");
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        q_pg.delete();
        q_fr.delete();
    endtask

    initial begin
        int s;
        for (int i = 0; i < 256; i++) ptmem[i] = (i * 11 + 7) & 63;
        ptmem[0] = 5; ptmem[1] = 6; ptmem[3] = 2;

        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", int'(done), 0, "done in reset");
        check("R9", int'(mem_rd), 0, "mem_rd in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R4, R1: worked example, logical 3 -> 23 via table read
        xlat(3, 0, "R2");
        // R3, R5: same page hits, logical 0 -> 20
        xlat(0, 0, "R3");
        // R1: logical 13 on page 3 -> 9, then hit at offset 2 -> 10
        xlat(13, 0, "R4");
        xlat(14, 0, "R5");
        // R1: every offset of page 1 (frame 6)
        for (int o = 0; o < 4; o++) xlat(4 + o, 0, "R1");
        // R6: page 2 fills the last slot, page 4 evicts page 0
        mem_lat = 2;
        xlat(8, 0, "R6");
        xlat(16, 0, "R6");
        xlat(12, 0, "R6");
        xlat(1, 0, "R6");
        xlat(5, 0, "R6");
        // R8: injected request during a slow walk is ignored
        mem_lat = 3;
        xlat(40, 1, "R8");
        // R7: flush, then move the table; old pages must be re-read
        do_flush();
        pt_base = 8'd100;
        xlat(13, 0, "R7");
        xlat(4, 0, "R7");
        xlat(13, 0, "R7");
        // R4: base wrap-around modulo address width
        do_flush();
        pt_base = 8'd250;
        mem_lat = 0;
        xlat(44, 0, "R4");
        // R5/R6: pseudo-random stream over 8 pages
        s = 17;
        for (int n = 0; n < 60; n++) begin
            s = (s * 37 + 11) % 251;
            mem_lat = s % 3;
            xlat(s & 31, 0, "R6");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule